// File: doc/BRIEF.md
# Nonlinear Carry-Select Adder

This block adds two 64-bit operands and a carry-in, producing a 64-bit sum and a carry-out. The word is cut into sections whose widths grow from the least significant end upward. The lowest section is one ripple-carry chain driven by the external carry-in. Every higher section holds two ripple-carry chains side by side. One assumes an incoming carry of 0 and the other assumes 1, so both candidate results are ready early. The true carry from the section below then picks one candidate through a multiplexer.

Section widths grow because carries reach the upper sections later. A wider section has more time to finish its own ripple before its select arrives. The worst-case path is therefore the ripple through the lowest section followed by one multiplexer per higher section. The adder core is combinational. Its result is captured in an output register with a synchronous active-high reset, so a result appears one clock after its operands are presented.

Top module: `csel_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum` and `cout` read 0 after that edge.
- R2: After each rising edge with `rst` low, the concatenation {`cout`, `sum`} equals `a` + `b` + `cin` for the operands sampled at that edge. The sum is treated as a 65-bit unsigned value, with `cout` as bit 64.
- R3: The default sections start at bit 0 with widths 4, 4, 5, 6, 7, 8, 9, 10 and 11, in that order. Their boundaries are therefore at bits 4, 8, 13, 19, 26, 34, 43 and 53. A carry leaving the top bit of any section enters the bottom bit of the next one. This holds both when the carry ripples up from `cin` and when it is generated by the section's top operand bits.
- R4: When every bit position propagates (`b` = ~`a`) and `cin` is 1, the carry crosses the whole word: `sum` is 0 and `cout` is 1.
- R5: When no bit position generates a carry (`a` & `b` = 0) and `cin` is 0, `sum` equals `a` | `b` and `cout` is 0.
- R6: The section widths are parameters. Any list of widths that adds up to the data width gives the same arithmetic result as R2. A list that does not add up is rejected when the design is elaborated.
- R7: `cout` is 1 exactly when the true sum reaches 2^W. With all-ones operands and `cin` = 1, `sum` is all ones and `cout` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands are sampled and the result is registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| a | input | W (64) | First operand |
| b | input | W (64) | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W (64) | Registered sum |
| cout | output | 1 | Registered carry out of the top bit |

## Verification
The bench drives a carry into every section boundary in two ways: by rippling it up from `cin`, and by generating it in the top bit of the section below. A select section with its multiplexer inputs swapped, or with the wrong select wiring, would show up as a missing or doubled power of two at exactly that boundary. The full-word propagate and no-generate patterns target a chain that forces a constant select, or that drops `cin`. A small three-section build is swept over every operand and carry combination. Any ripple-equation or section-offset error then shows up as a sum mismatch. The reset check catches a register that does not clear synchronously.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned MAX_SECTIONS = 32;
  localparam int unsigned FIELD_BITS   = 8;

  typedef logic [MAX_SECTIONS*FIELD_BITS-1:0] width_list_t;

  function automatic int unsigned width_of(input width_list_t lst, input int unsigned k);
    return int'(lst[FIELD_BITS*k +: FIELD_BITS]);
  endfunction

  function automatic int unsigned base_of(input width_list_t lst, input int unsigned k);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < k; i++) acc += width_of(lst, i);
    return acc;
  endfunction
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  always_comb begin
    logic [W:0] c;
    logic [W-1:0] p;
    c[0] = ci;
    p    = x ^ y;
    for (int i = 0; i < int'(W); i++) begin
      s[i]   = p[i] ^ c[i];
      c[i+1] = (x[i] & y[i]) | (p[i] & c[i]);
    end
    co = c[W];
  end
endmodule

// File: rtl/csel_section.sv
module csel_section #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] s_lo, s_hi;
  logic         co_lo, co_hi;

  csel_ripple #(.W(W)) u_zero (.x(x), .y(y), .ci(1'b0), .s(s_lo), .co(co_lo));
  csel_ripple #(.W(W)) u_one  (.x(x), .y(y), .ci(1'b1), .s(s_hi), .co(co_hi));

  assign s  = sel ? s_hi  : s_lo;
  assign co = sel ? co_hi : co_lo;
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int unsigned W    = 64,
  parameter int unsigned NSEC = 9,
  parameter logic [8*NSEC-1:0] SEC_W =
    {8'd11, 8'd10, 8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd4}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam csel_pkg::width_list_t LIST = csel_pkg::width_list_t'(SEC_W);
  localparam int unsigned TOTAL = csel_pkg::base_of(LIST, NSEC);

  // R6: the section list must cover the word exactly
  if (TOTAL != W || NSEC > csel_pkg::MAX_SECTIONS) begin : g_bad_split
    $error("section widths do not add up to the data width");
  end

  logic [NSEC:0]  chain;
  logic [W-1:0]   sum_c;

  assign chain[0] = cin;

  for (genvar k = 0; k < int'(NSEC); k++) begin : g_sec
    localparam int unsigned LO = csel_pkg::base_of(LIST, k);
    localparam int unsigned WK = csel_pkg::width_of(LIST, k);
    if (k == 0) begin : g_base
      csel_ripple #(.W(WK)) u_rc (
        .x(a[LO +: WK]), .y(b[LO +: WK]), .ci(chain[k]),
        .s(sum_c[LO +: WK]), .co(chain[k+1]));
    end else begin : g_sel
      csel_section #(.W(WK)) u_cs (
        .x(a[LO +: WK]), .y(b[LO +: WK]), .sel(chain[k]),
        .s(sum_c[LO +: WK]), .co(chain[k+1]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_c;
      cout <= chain[NSEC];
    end
  end
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout
);
  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (sum == '0 && !cout));

  a_r2_sum_matches: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !rst) |=>
      ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{W{1'b0}}, $past(cin)})));

  a_r4_full_propagate: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !rst && b == ~a && cin) |=> (cout && sum == '0));

  a_r5_no_generate: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !rst && (a & b) == '0 && !cin) |=> (!cout && sum == $past(a | b)));

  a_r7_all_ones: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !rst && &a && &b && cin) |=> (cout && &sum));
endmodule

bind csel_adder csel_adder_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

// File: tb/sim_csel_adder.sv
module sim_csel_adder;
  localparam int W  = 64;
  localparam int SW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0]  a = '0, b = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  sum;
  logic          cout;
  logic [SW-1:0] sa = '0, sb = '0;
  logic          scin = 1'b0;
  logic [SW-1:0] ssum;
  logic          scout;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  csel_adder u0 (.clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  csel_adder #(.W(SW), .NSEC(3), .SEC_W({8'd3, 8'd2, 8'd2})) u1 (
    .clk(clk), .rst(rst), .a(sa), .b(sb), .cin(scin), .sum(ssum), .cout(scout));

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    logic [W:0] exp;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    exp = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    @(posedge clk); #1;
    check(req, {cout, sum}, exp);
  endtask

  initial begin
    int bounds [8] = '{4, 8, 13, 19, 26, 34, 43, 53};
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {cout, sum}, '0);
    @(negedge clk); rst = 1'b0;

    apply("R2 basic", 64'd5, 64'd7, 1'b0);
    apply("R2 cin", 64'd100, 64'd23, 1'b1);

    // R1: reset applied after a nonzero result
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset after data", {cout, sum}, '0);
    @(negedge clk); rst = 1'b0;

    // R3: carry into each boundary, rippled and generated
    foreach (bounds[i]) begin
      apply("R3 ripple into boundary", (64'd1 << bounds[i]) - 64'd1, 64'd0, 1'b1);
      apply("R3 generate at boundary", 64'd1 << (bounds[i] - 1), 64'd1 << (bounds[i] - 1), 1'b0);
    end

    apply("R4 full propagate", 64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b1);
    apply("R4 full propagate ones", '1, '0, 1'b1);
    apply("R5 no generate", 64'hF0F0_0F0F_AAAA_5555, 64'h0F0F_F0F0_5555_AAAA, 1'b0);
    apply("R5 sparse", 64'h8000_0000_0001_0010, 64'h0000_0400_0000_0001, 1'b0);
    apply("R7 all ones", '1, '1, 1'b1);
    apply("R7 top carry", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);

    for (int i = 0; i < 200; i++)
      apply("R2 mixed", {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));

    // R6: exhaustive sweep of the small three-section build
    for (int v = 0; v < (1 << (2*SW+1)); v++) begin
      logic [SW:0] sexp;
      @(negedge clk);
      sa   = v[SW-1:0];
      sb   = v[2*SW-1:SW];
      scin = v[2*SW];
      sexp = {1'b0, sa} + {1'b0, sb} + {{SW{1'b0}}, scin};
      @(posedge clk); #1;
      check("R6 small split", {{(W-SW){1'b0}}, scout, ssum}, {{(W-SW){1'b0}}, sexp});
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule